// File: doc/BRIEF.md
# Frame-Aware Packet FIFO with Service-Request Control

This block is the data buffer of one USB endpoint. Words enter through a write port and leave through a read port. Alongside the plain word count, the FIFO tracks where each data frame (packet) ends. A host-side configuration write selects the operating modes, loads a 16-bit inactivity count and sets six interrupt masks. The same write can arm an end-of-frame flag that tags the next data write as the last word of its frame. A peripheral-side strobe pair reports whether each packet transfer succeeded. The block drives two service requests, frame-ready and alarm, plus a masked six-bit flag vector and a combined interrupt line.

In frame mode, only words up to the end of the most recently completed frame can be read. Because only that single boundary is kept, one burst of reads may drain several frames. Shadow mode is a sub-mode of frame mode. It withholds a frame until the peripheral confirms the packet. A failed transfer rolls the write pointer back to the last confirmed boundary, which discards the unconfirmed words. Timer mode is also a sub-mode of frame mode. It replaces the per-frame request with a single pulse, issued after a programmed number of idle cycles if a complete frame is waiting. The high-water alarm is never delayed by the timer.

The shadow tracker has two states. It sits in SH_IDLE until an end-of-frame write arrives in shadow mode (transition IDLE→HOLD). It stays in SH_HOLD until a packet report arrives or shadow mode is left (transition HOLD→IDLE). If a new frame closes in the same cycle as the report, it stays in HOLD. The inactivity timer also has two states. Any FIFO access moves it into TM_RUN and reloads the count (transition IDLE→RUN, RUN→RUN). It counts down, pulses on the cycle it reaches zero if a frame is present, and returns to TM_IDLE (transition RUN→IDLE). It also returns to TM_IDLE whenever timer mode is not in effect. DEPTH must be a power of two.

Top module: `frame_fifo_ctrl`

## Requirements
- R1: After reset, all mode bits, the end-of-frame flag and the count are zero, the FIFO is empty, frame_ready, alarm, flags and irq are 0, and the mask vector is 6'b101010 (mask bits 1, 3 and 5 set).
- R2: With frame mode off, frame_ready equals "FIFO not empty", the end-of-frame flag has no effect, and words are read in write order.
- R3: With frame mode on, a word becomes readable only once the frame containing it has been closed. frame_ready is 1 while at least one closed frame is unread. Back-to-back reads may drain several closed frames.
- R4: A configuration write with cfg_eof=1 tags only the next accepted data write as end of frame. The flag then clears, and later writes do not close a frame.
- R5: In shadow mode (frame and shadow both on), a closed frame is not readable and raises neither frame_ready nor alarm until pkt_done is asserted with pkt_ok=1.
- R6: When pkt_done is asserted with pkt_ok=0, flag bit 1 (frame error) becomes sticky-set. In shadow mode, all words after the last confirmed frame boundary are also dropped from the FIFO.
- R7: Shadow mode and timer mode each have no effect while frame mode is off.
- R8: In timer mode, frame_ready is a single-cycle pulse. It is issued exactly N cycles after the clock edge of the last read or write, where N is the loaded count, and only if a closed frame is present. It then stays 0 until the next access.
- R9: alarm (and flag bit 2) is 1 whenever the fill level is at least HI_MARK, independent of timer mode. In shadow mode the fill level counts confirmed words only.
- R10: A write to a full FIFO is dropped and sets sticky flag bit 4 (overflow). Stored data is unchanged.
- R11: A read when no word is readable leaves the read pointer in place and sets sticky flag bit 3 (underflow).
- R12: flags = raw & ~mask and irq = OR of flags. Raw bit 0 is frame_ready. Bits 1, 3 and 4 are sticky and are cleared by writing 1 to the matching bit of sts_clr; a new event in the same cycle wins over the clear.
- R13: Flag bit 5 (transmit watermark) is 1 while the fill level is at most LO_MARK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load all configuration fields below |
| cfg_frame | input | 1 | Frame mode enable |
| cfg_shadow | input | 1 | Shadow sub-mode enable |
| cfg_timer | input | 1 | Timer sub-mode enable |
| cfg_eof | input | 1 | Tag next data write as end of frame |
| cfg_count | input | CNT_W | Inactivity count for timer mode |
| cfg_mask | input | 6 | Interrupt masks, 1 = masked |
| sts_clr | input | 6 | Write-1-to-clear for sticky flags |
| wr_en | input | 1 | Push wr_data |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Pop a word |
| rd_data | output | DATA_W | Word at the read pointer |
| pkt_done | input | 1 | Peripheral packet report strobe |
| pkt_ok | input | 1 | Packet report result, 1 = success |
| frame_ready | output | 1 | Frame-ready service request |
| alarm | output | 1 | High-water service request |
| flags | output | 6 | Masked status flags |
| irq | output | 1 | OR of masked flags |

## Verification
The bench builds the block with DEPTH=8, HI_MARK=6 and LO_MARK=2. With these values the full, overflow, high-water and low-water boundaries are reached in a handful of writes, and a single run can cover both edges of each watermark. The count field is set to 5 for the timer pulse timing and to 1000 to hold the timer off during the alarm test. Shadow commit and rollback use two-word frames, so a dropped frame leaves the FIFO visibly empty.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
    typedef enum logic {SH_IDLE, SH_HOLD} sh_state_t;
    typedef enum logic {TM_IDLE, TM_RUN} tm_state_t;

    localparam int FL_PEND = 0;
    localparam int FL_FERR = 1;
    localparam int FL_RXMK = 2;
    localparam int FL_UDF  = 3;
    localparam int FL_OVF  = 4;
    localparam int FL_TXMK = 5;
    localparam int FL_N    = 6;

    localparam logic [FL_N-1:0] MASK_RST = 6'b101010;
endpackage

// File: rtl/ffc_store.sv
module ffc_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ffc_ptrs.sv
module ffc_ptrs
    import ffc_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_req,
    input  logic                   rd_req,
    input  logic                   eof_mark,
    input  logic                   frame_on,
    input  logic                   shadow_on,
    input  logic                   pkt_done,
    input  logic                   pkt_ok,
    output logic [$clog2(DEPTH):0] wr_ptr,
    output logic [$clog2(DEPTH):0] rd_ptr,
    output logic [$clog2(DEPTH):0] fill,
    output logic [$clog2(DEPTH):0] ready_cnt,
    output logic                   wr_fire,
    output logic                   rd_fire,
    output logic                   ovf_evt,
    output logic                   udf_evt,
    output logic                   ferr_evt
);
    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW-1:0] ONE  = PW'(1);
    localparam logic [PW-1:0] FULL = PW'(DEPTH);

    sh_state_t     sh_q, sh_d;
    logic [PW-1:0] frm_ptr, cand_ptr, wr_nxt, rd_nxt;
    logic          full, rollback, commit, closes;

    assign fill      = wr_ptr - rd_ptr;
    assign ready_cnt = frame_on ? (frm_ptr - rd_ptr) : fill;
    assign full      = (fill == FULL);
    assign rollback  = shadow_on && pkt_done && !pkt_ok;
    assign commit    = shadow_on && pkt_done && pkt_ok && (sh_q == SH_HOLD);
    assign wr_fire   = wr_req && !full && !rollback;
    assign rd_fire   = rd_req && (ready_cnt != '0);
    assign ovf_evt   = wr_req && full;
    assign udf_evt   = rd_req && (ready_cnt == '0);
    assign ferr_evt  = pkt_done && !pkt_ok;
    assign closes    = wr_fire && eof_mark;
    assign wr_nxt    = rollback ? frm_ptr : (wr_fire ? wr_ptr + ONE : wr_ptr);
    assign rd_nxt    = rd_fire ? rd_ptr + ONE : rd_ptr;

    // shadow tracker: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= SH_IDLE;
        end else begin
            sh_q <= sh_d;
        end
    end

    // shadow tracker: next state
    always_comb begin
        sh_d = sh_q;
        unique case (sh_q)
            SH_IDLE: if (shadow_on && closes) sh_d = SH_HOLD;
            SH_HOLD: begin
                if (!shadow_on) begin
                    sh_d = SH_IDLE;
                end else if (pkt_done) begin
                    sh_d = closes ? SH_HOLD : SH_IDLE;
                end
            end
        endcase
    end

    // pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            frm_ptr  <= '0;
            cand_ptr <= '0;
        end else begin
            wr_ptr <= wr_nxt;
            rd_ptr <= rd_nxt;
            if (!frame_on) begin
                frm_ptr  <= wr_nxt;
                cand_ptr <= wr_nxt;
            end else if (!shadow_on) begin
                if (closes) begin
                    frm_ptr  <= wr_ptr + ONE;
                    cand_ptr <= wr_ptr + ONE;
                end
            end else if (rollback) begin
                cand_ptr <= frm_ptr;
            end else begin
                if (commit) frm_ptr <= cand_ptr;
                if (closes) cand_ptr <= wr_ptr + ONE;
            end
        end
    end

    assert_fill_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL);
    assert_frame_inside_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready_cnt <= fill);
    assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_on && !(pkt_done && pkt_ok) |=> $stable(frm_ptr));
    assert_rollback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> (wr_ptr == $past(frm_ptr)));
    assert_udf_no_move_R11: assert property (@(posedge clk) disable iff (!rst_n)
        udf_evt |=> $stable(rd_ptr));
endmodule

// File: rtl/ffc_timer.sv
module ffc_timer
    import ffc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             access,
    input  logic [CNT_W-1:0] load_val,
    input  logic             frame_avail,
    output logic             fire
);
    tm_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TM_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!enable) begin
            st_d = TM_IDLE;
        end else if (access) begin
            st_d  = TM_RUN;
            cnt_d = load_val;
        end else begin
            unique case (st_q)
                TM_IDLE: st_d = TM_IDLE;
                TM_RUN: begin
                    if (cnt_q == '0) st_d = TM_IDLE;
                    else cnt_d = cnt_q - 1'b1;
                end
            endcase
        end
    end

    // output
    always_comb begin
        fire = enable && (st_q == TM_RUN) && (cnt_q == '0) && !access && frame_avail;
    end

    assert_tmr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/ffc_status.sv
module ffc_status
    import ffc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ovf_evt,
    input  logic            udf_evt,
    input  logic            ferr_evt,
    input  logic            pend,
    input  logic            rx_mark,
    input  logic            tx_mark,
    input  logic [FL_N-1:0] clr,
    input  logic [FL_N-1:0] mask,
    output logic [FL_N-1:0] flags,
    output logic            irq
);
    logic            ovf_q, udf_q, ferr_q;
    logic [FL_N-1:0] raw;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            udf_q  <= 1'b0;
            ferr_q <= 1'b0;
        end else begin
            ovf_q  <= (ovf_q  && !clr[FL_OVF])  || ovf_evt;
            udf_q  <= (udf_q  && !clr[FL_UDF])  || udf_evt;
            ferr_q <= (ferr_q && !clr[FL_FERR]) || ferr_evt;
        end
    end

    always_comb begin
        raw          = '0;
        raw[FL_PEND] = pend;
        raw[FL_FERR] = ferr_q;
        raw[FL_RXMK] = rx_mark;
        raw[FL_UDF]  = udf_q;
        raw[FL_OVF]  = ovf_q;
        raw[FL_TXMK] = tx_mark;
        flags        = raw & ~mask;
        irq          = |flags;
    end

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && !clr[FL_OVF] |=> ovf_q);
    assert_udf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        udf_evt |=> udf_q);
endmodule

// File: rtl/frame_fifo_ctrl.sv
module frame_fifo_ctrl
    import ffc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 16,
    parameter int HI_MARK = 12,
    parameter int LO_MARK = 4,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_frame,
    input  logic              cfg_shadow,
    input  logic              cfg_timer,
    input  logic              cfg_eof,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [5:0]        cfg_mask,
    input  logic [5:0]        sts_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pkt_done,
    input  logic              pkt_ok,
    output logic              frame_ready,
    output logic              alarm,
    output logic [5:0]        flags,
    output logic              irq
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic             md_frame, md_shadow, md_timer, eof_arm;
    logic [CNT_W-1:0] tmr_load;
    logic [FL_N-1:0]  irq_mask;

    logic [PW-1:0] wr_ptr, rd_ptr, fill, ready_cnt, mark_lvl;
    logic          wr_fire, rd_fire, ovf_evt, udf_evt, ferr_evt;
    logic          shadow_on, timer_on, tmr_fire, have_frame, tx_mark;

    assign shadow_on = md_frame && md_shadow;
    assign timer_on  = md_frame && md_timer;

    // configuration register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            md_frame  <= 1'b0;
            md_shadow <= 1'b0;
            md_timer  <= 1'b0;
            eof_arm   <= 1'b0;
            tmr_load  <= '0;
            irq_mask  <= MASK_RST;
        end else begin
            if (wr_fire) eof_arm <= 1'b0;
            if (cfg_we) begin
                md_frame  <= cfg_frame;
                md_shadow <= cfg_shadow;
                md_timer  <= cfg_timer;
                eof_arm   <= cfg_eof;
                tmr_load  <= cfg_count;
                irq_mask  <= cfg_mask;
            end
        end
    end

    ffc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (wr_ptr[AW-1:0]),
        .wdata (wr_data),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (rd_data)
    );

    ffc_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_en),
        .rd_req    (rd_en),
        .eof_mark  (eof_arm),
        .frame_on  (md_frame),
        .shadow_on (shadow_on),
        .pkt_done  (pkt_done),
        .pkt_ok    (pkt_ok),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .fill      (fill),
        .ready_cnt (ready_cnt),
        .wr_fire   (wr_fire),
        .rd_fire   (rd_fire),
        .ovf_evt   (ovf_evt),
        .udf_evt   (udf_evt),
        .ferr_evt  (ferr_evt)
    );

    assign have_frame = (ready_cnt != '0);

    ffc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (timer_on),
        .access      (wr_en || rd_en),
        .load_val    (tmr_load),
        .frame_avail (have_frame),
        .fire        (tmr_fire)
    );

    // service request outputs
    always_comb begin
        mark_lvl    = shadow_on ? ready_cnt : fill;
        alarm       = (mark_lvl >= PW'(HI_MARK));
        tx_mark     = (fill <= PW'(LO_MARK));
        frame_ready = timer_on ? tmr_fire : have_frame;
    end

    ffc_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf_evt  (ovf_evt),
        .udf_evt  (udf_evt),
        .ferr_evt (ferr_evt),
        .pend     (frame_ready),
        .rx_mark  (alarm),
        .tx_mark  (tx_mark),
        .clr      (sts_clr),
        .mask     (irq_mask),
        .flags    (flags),
        .irq      (irq)
    );

    assert_eof_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire && !cfg_we |=> !eof_arm);
    assert_rd_only_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |-> (ready_cnt != '0));
endmodule

// File: tb/sim_frame_fifo_ctrl.sv
`timescale 1ns/1ps
module sim_frame_fifo_ctrl;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 0, cfg_frame = 0, cfg_shadow = 0, cfg_timer = 0, cfg_eof = 0;
    logic [15:0]   cfg_count = '0;
    logic [5:0]    cfg_mask = '0, sts_clr = '0;
    logic          wr_en = 0, rd_en = 0, pkt_done = 0, pkt_ok = 0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic          frame_ready, alarm, irq;
    logic [5:0]    flags;

    int vectors = 0, miscompares = 0;
    bit finished = 0;
    bit rd_noexp = 0;
    string mon_tag = "R2";
    logic [DW-1:0] exp_q[$];

    bit m_frame = 0, m_shadow = 0, m_timer = 0;
    logic [15:0] m_count = '0;
    logic [5:0]  m_mask = '0;

    always #2.5 clk = ~clk;

    frame_fifo_ctrl #(.DATA_W(DW), .DEPTH(8), .HI_MARK(6), .LO_MARK(2), .CNT_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_frame(cfg_frame),
        .cfg_shadow(cfg_shadow), .cfg_timer(cfg_timer), .cfg_eof(cfg_eof),
        .cfg_count(cfg_count), .cfg_mask(cfg_mask), .sts_clr(sts_clr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .pkt_done(pkt_done), .pkt_ok(pkt_ok), .frame_ready(frame_ready),
        .alarm(alarm), .flags(flags), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compares every popped word with the scoreboard head
    always @(negedge clk) begin
        if (rd_en && !rd_noexp) begin
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL %s: actual %0h expected <none>", mon_tag, rd_data);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    miscompares++;
                    $display("FAIL %s: actual %0h expected %0h", mon_tag, rd_data, e);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input bit eof);
        cfg_we = 1; cfg_frame = m_frame; cfg_shadow = m_shadow; cfg_timer = m_timer;
        cfg_count = m_count; cfg_mask = m_mask; cfg_eof = eof;
        step();
        cfg_we = 0; cfg_eof = 0;
    endtask

    task automatic set_mode(input bit f, input bit s, input bit t, input logic [15:0] n);
        m_frame = f; m_shadow = s; m_timer = t; m_count = n; m_mask = 6'b000000;
        cfg_write(0);
    endtask

    // driver: pushes the expected word into the scoreboard when it must come out
    task automatic push(input logic [DW-1:0] d, input bit eof, input bit keep);
        if (eof) cfg_write(1);
        wr_en = 1; wr_data = d;
        step();
        wr_en = 0;
        if (keep) exp_q.push_back(d);
    endtask

    task automatic pop(input string tag);
        mon_tag = tag;
        rd_en = 1;
        step();
        rd_en = 0;
    endtask

    task automatic packet(input bit ok);
        pkt_done = 1; pkt_ok = ok;
        step();
        pkt_done = 0; pkt_ok = 0;
    endtask

    task automatic clear(input logic [5:0] c);
        sts_clr = c;
        step();
        sts_clr = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 frame_ready", frame_ready, 0);
        chk("R1 alarm", alarm, 0);
        chk("R1 flags", flags, 0);
        chk("R1 irq", irq, 0);

        // unmasking everything exposes the transmit watermark that the reset mask hid
        set_mode(0, 0, 0, 0);
        @(negedge clk);
        chk("R12 flags unmasked", flags, 6'b100000);
        chk("R12 irq", irq, 1);

        // plain FIFO mode
        push(8'h11, 1, 1);
        @(negedge clk);
        chk("R2 frame_ready non-empty", frame_ready, 1);
        push(8'h12, 0, 1);
        push(8'h13, 0, 1);
        @(negedge clk);
        chk("R13 above low mark", flags[5], 0);
        repeat (3) pop("R2");
        @(negedge clk);
        chk("R2 frame_ready empty", frame_ready, 0);

        // frame mode
        set_mode(1, 0, 0, 0);
        push(8'h21, 0, 1);
        push(8'h22, 0, 1);
        @(negedge clk);
        chk("R3 open frame not ready", frame_ready, 0);
        rd_noexp = 1;
        pop("R11");
        rd_noexp = 0;
        @(negedge clk);
        chk("R11 underflow flag", flags[3], 1);
        clear(6'b001000);
        @(negedge clk);
        chk("R12 underflow cleared", flags[3], 0);
        push(8'h23, 1, 1);
        @(negedge clk);
        chk("R3 closed frame ready", frame_ready, 1);
        push(8'h24, 0, 1);
        repeat (3) pop("R11 data kept");
        @(negedge clk);
        chk("R4 eof used once", frame_ready, 0);
        push(8'h25, 1, 1);
        push(8'h26, 0, 1);
        push(8'h27, 1, 1);
        repeat (4) pop("R3 multi-frame drain");
        @(negedge clk);
        chk("R3 drained", frame_ready, 0);

        // shadow mode
        set_mode(1, 1, 0, 0);
        push(8'h31, 0, 1);
        push(8'h32, 1, 1);
        @(negedge clk);
        chk("R5 held before ack", frame_ready, 0);
        packet(1);
        @(negedge clk);
        chk("R5 ready after ack", frame_ready, 1);
        repeat (2) pop("R5");
        push(8'h33, 0, 0);
        push(8'h34, 1, 0);
        packet(0);
        @(negedge clk);
        chk("R6 frame error flag", flags[1], 1);
        chk("R6 not ready", frame_ready, 0);
        chk("R6 dropped data empties FIFO", flags[5], 1);
        push(8'h35, 1, 1);
        packet(1);
        @(negedge clk);
        chk("R6 next frame ready", frame_ready, 1);
        pop("R6");
        @(negedge clk);
        chk("R6 nothing left", frame_ready, 0);
        clear(6'b000010);

        // sub-modes without frame mode
        set_mode(0, 1, 0, 0);
        push(8'h41, 0, 1);
        @(negedge clk);
        chk("R7 shadow inert", frame_ready, 1);
        pop("R7");
        set_mode(0, 0, 1, 20);
        push(8'h42, 0, 1);
        @(negedge clk);
        chk("R7 timer inert", frame_ready, 1);
        pop("R7");

        // timer mode
        set_mode(1, 0, 1, 5);
        push(8'h51, 1, 1);
        begin
            int n = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (frame_ready) break;
                n++;
            end
            chk("R8 pulse delay", n, 5);
        end
        @(negedge clk);
        chk("R8 pulse width", frame_ready, 0);
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (frame_ready) seen++;
            end
            chk("R8 idle after pulse", seen, 0);
        end
        pop("R8");

        // high-water alarm under timer mode
        set_mode(1, 0, 1, 1000);
        for (int i = 0; i < 5; i++) push(DW'(8'h70 + i), 0, 1);
        @(negedge clk);
        chk("R9 below high mark", alarm, 0);
        push(8'h75, 1, 1);
        @(negedge clk);
        chk("R9 alarm at high mark", alarm, 1);
        chk("R9 flag", flags[2], 1);
        repeat (6) pop("R9");
        @(negedge clk);
        chk("R9 alarm off", alarm, 0);

        // overflow and low watermark
        set_mode(0, 0, 0, 0);
        for (int i = 0; i < 8; i++) push(DW'(8'h60 + i), 0, 1);
        @(negedge clk);
        chk("R10 full no overflow", flags[4], 0);
        push(8'h6F, 0, 0);
        @(negedge clk);
        chk("R10 overflow flag", flags[4], 1);
        repeat (8) pop("R10 data intact");
        @(negedge clk);
        chk("R10 overflow sticky", flags[4], 1);
        clear(6'b010000);
        @(negedge clk);
        chk("R10 overflow cleared", flags[4], 0);
        push(8'h81, 0, 1);
        push(8'h82, 0, 1);
        @(negedge clk);
        chk("R13 at low mark", flags[5], 1);
        push(8'h83, 0, 1);
        @(negedge clk);
        chk("R13 above low mark", flags[5], 0);
        repeat (3) pop("R2");
        @(negedge clk);
        chk("R2 scoreboard empty", exp_q.size(), 0);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule